// File: doc/BRIEF.md
# Configurable Bidirectional Pin Bank

This block drives and samples sixteen general-purpose pads, grouped as two eight-bit ports. Each pin can be set as an input or an output. Each pin can have its polarity inverted, and each output pin can drive as push-pull or open-drain. The direction, inversion, drive-mode and port-enable settings come in as static bytes from a configuration register file elsewhere in the chip. The output data level of each port is held in a latch inside this block. Software writes that latch a whole port byte at a time, through a per-port write strobe.

For each pin the block produces an output-enable and an output-value for the pad. For each port it returns a readback byte. An input pin reads back its pad level, passed through a two-flop synchroniser and then corrected for inversion. An output pin reads back its stored latch value. Software therefore changes one bit by reading the byte, changing that bit and writing the byte back, and the other output bits of the port stay the same. A port whose enable bit is clear releases all of its pads, reads back zero and ignores writes.

Top module: `gpio_pin_bank`

## Requirements
- R1: After a synchronous active-low reset, every output latch holds 0 and every synchroniser stage holds 0. With push-pull outputs on an enabled port, every pad is therefore driven low and every readback bit is 0.
- R2: Pin p (0..15) belongs to port p/8 at bit p%8. On every flattened 16-bit bus (configuration, pads and readback), bit p belongs to pin p.
- R3: A direction bit of 1 makes the pin an input. An input pin never asserts its output-enable, and its pad_out is 0.
- R4: On an enabled port, a push-pull output pin (direction 0, drive-mode 0) holds pad_oe at 1. Its pad_out equals the latch bit XOR the inversion bit.
- R5: An open-drain output pin (drive-mode bit 1) has pad_out 0. It asserts pad_oe only when the latch bit XOR the inversion bit is 0, and releases the pad (pad_oe 0) when that value is 1.
- R6: An inversion bit of 1 inverts the pin in both directions. The driven level becomes the inverse of the latch, and the readback of an input becomes the inverse of the synchronised pad.
- R7: A change on pad_in for an input pin appears in the readback after exactly two rising clock edges, and not after one.
- R8: An output pin reads back its latch bit unchanged. Neither the inversion bit nor the pad level affects it.
- R9: Port k runs only while port_en bit k is 1. While that bit is 0, the port's pad_oe, pad_out and readback bits are all 0.
- R10: A write strobe to a disabled port is ignored. The latch keeps its old value and shows it again once the port is re-enabled.
- R11: A write to an enabled port loads the whole byte into that port's latch at the rising edge where the strobe is high, and leaves the other port's latch unchanged. A read-modify-write of a single bit therefore leaves the port's other output bits as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 2 | Port enable, bit k for port k |
| cfg_dir | input | 16 | Direction per pin, 1 = input |
| cfg_inv | input | 16 | Polarity inversion per pin |
| cfg_od | input | 16 | Drive mode per pin, 1 = open-drain |
| dat_we | input | 2 | Data latch write strobe, bit k for port k |
| dat_wdata | input | 8 | Byte written to the strobed port latch |
| pad_in | input | 16 | Pad levels seen by the chip |
| rd_data | output | 16 | Readback, port k in bits 8k+7..8k |
| pad_oe | output | 16 | Pad output-enable per pin |
| pad_out | output | 16 | Pad output value per pin |

## Verification
The assertions take the configuration bytes to be stable in the cycles they check. They also take the write strobe and its data to be clean at the clock edge. The pad inputs may be fully asynchronous; only the synchroniser's first stage is checked against them. The bench changes configuration, strobes and pad levels only at falling edges, and it holds pad levels for at least two edges before it compares readback against its model. So every sampled value comes from a settled configuration.

// File: rtl/gpio_pin_bank_pkg.sv
// Package: shared encodings for the pin bank.
// Assumes: single-bit encodings match the configuration register bits.
package gpio_pin_bank_pkg;

    typedef enum logic {
        PIN_OUTPUT = 1'b0,
        PIN_INPUT  = 1'b1
    } pin_dir_e;

    typedef enum logic {
        DRIVE_PUSHPULL  = 1'b0,
        DRIVE_OPENDRAIN = 1'b1
    } drive_mode_e;

    localparam int unsigned DEF_PORT_W    = 8;
    localparam int unsigned DEF_NUM_PORTS = 2;
    localparam int unsigned DEF_SYNC_LEN  = 2;

endpackage

// File: rtl/pb_sync.sv
// pb_sync: multi-bit chain of flops that brings asynchronous pad levels into
// the clock domain. Each bit is independent; no coherence across bits.
// Assumes: LEN >= 2, synchronous active-low reset clears every stage.
module pb_sync #(
    parameter int unsigned W   = 8,
    parameter int unsigned LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage [LEN];

    // Shift the pad levels one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(LEN); i++) stage[i] <= '0;
        end else begin
            stage[0] <= din;
            for (int i = 1; i < int'(LEN); i++) stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[LEN-1];

    AST_SYNC_FIRST_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage[0] == $past(din))); // R7

endmodule

// File: rtl/pb_drive.sv
// pb_drive: per-pin pad control and readback selection.
// Assumes: inputs are settled register or synchroniser outputs.
module pb_drive
    import gpio_pin_bank_pkg::*;
(
    input  logic en,
    input  logic dir,
    input  logic inv,
    input  logic od,
    input  logic lat,
    input  logic syn,
    output logic oe,
    output logic out,
    output logic rd
);

    pin_dir_e    dir_e;
    drive_mode_e mode_e;
    logic        level;

    assign dir_e  = pin_dir_e'(dir);
    assign mode_e = drive_mode_e'(od);
    assign level  = lat ^ inv;

    // Select pad drive from direction, drive mode and the polarity-corrected level.
    always_comb begin
        oe  = 1'b0;
        out = 1'b0;
        if (en && dir_e == PIN_OUTPUT) begin
            if (mode_e == DRIVE_PUSHPULL) begin
                oe  = 1'b1;
                out = level;
            end else begin
                oe  = ~level;
                out = 1'b0;
            end
        end
    end

    // Select readback: synchronised pad for inputs, latch for outputs.
    always_comb begin
        if (!en)                    rd = 1'b0;
        else if (dir_e == PIN_INPUT) rd = syn ^ inv;
        else                        rd = lat;
    end

endmodule

// File: rtl/pb_port.sv
// pb_port: one port of the bank. Holds the output data latch, the input
// synchroniser, and one pb_drive per pin.
// Assumes: configuration inputs come from a register file and change rarely.
module pb_port #(
    parameter int unsigned W        = 8,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] inv,
    input  logic [W-1:0] od,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] rd,
    output logic [W-1:0] oe,
    output logic [W-1:0] out
);

    logic [W-1:0] latch;
    logic [W-1:0] synced;

    // Load the whole port byte when strobed while the port is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)         latch <= '0;
        else if (we && en)  latch <= wdata;
    end

    pb_sync #(.W(W), .LEN(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (synced)
    );

    for (genvar b = 0; b < int'(W); b++) begin : g_pin
        pb_drive u_drive (
            .en  (en),
            .dir (dir[b]),
            .inv (inv[b]),
            .od  (od[b]),
            .lat (latch[b]),
            .syn (synced[b]),
            .oe  (oe[b]),
            .out (out[b]),
            .rd  (rd[b])
        );
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && en) |=> (latch == $past(wdata))); // R11
    AST_WRITE_IGNORED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || !en) |=> $stable(latch)); // R10
    AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |-> (oe == '0 && out == '0 && rd == '0)); // R9
    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((oe & dir) == '0)); // R3
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((out & od) == '0)); // R5
    AST_OUT_READS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ((rd & ~dir) == (latch & ~dir))); // R8

endmodule

// File: rtl/gpio_pin_bank.sv
// gpio_pin_bank: bank of NUM_PORTS ports of PORT_W pins each.
// Pin p sits in port p/PORT_W at bit p%PORT_W; flattened buses index by pin.
// Assumes: pad_in is asynchronous; all other inputs are in the clk domain.
module gpio_pin_bank
    import gpio_pin_bank_pkg::*;
#(
    parameter int unsigned PORT_W    = DEF_PORT_W,
    parameter int unsigned NUM_PORTS = DEF_NUM_PORTS,
    parameter int unsigned SYNC_LEN  = DEF_SYNC_LEN,
    localparam int unsigned PINS     = PORT_W * NUM_PORTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_en,
    input  logic [PINS-1:0]      cfg_dir,
    input  logic [PINS-1:0]      cfg_inv,
    input  logic [PINS-1:0]      cfg_od,
    input  logic [NUM_PORTS-1:0] dat_we,
    input  logic [PORT_W-1:0]    dat_wdata,
    input  logic [PINS-1:0]      pad_in,
    output logic [PINS-1:0]      rd_data,
    output logic [PINS-1:0]      pad_oe,
    output logic [PINS-1:0]      pad_out
);

    for (genvar k = 0; k < int'(NUM_PORTS); k++) begin : g_port
        pb_port #(.W(PORT_W), .SYNC_LEN(SYNC_LEN)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (port_en[k]),
            .dir    (cfg_dir[k*PORT_W +: PORT_W]),
            .inv    (cfg_inv[k*PORT_W +: PORT_W]),
            .od     (cfg_od[k*PORT_W +: PORT_W]),
            .we     (dat_we[k]),
            .wdata  (dat_wdata),
            .pin_in (pad_in[k*PORT_W +: PORT_W]),
            .rd     (rd_data[k*PORT_W +: PORT_W]),
            .oe     (pad_oe[k*PORT_W +: PORT_W]),
            .out    (pad_out[k*PORT_W +: PORT_W])
        );
    end

    AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | cfg_dir | cfg_od) == {PINS{1'b1}}) || (port_en != {NUM_PORTS{1'b1}})); // R4

endmodule

// File: tb/sim_gpio_pin_bank.sv
module sim_gpio_pin_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  port_en;
    logic [15:0] cfg_dir, cfg_inv, cfg_od, pad_in;
    logic [1:0]  dat_we;
    logic [7:0]  dat_wdata;
    logic [15:0] rd_data, pad_oe, pad_out;

    logic [15:0] sh;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pin_bank u0 (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .cfg_dir(cfg_dir),
        .cfg_inv(cfg_inv), .cfg_od(cfg_od), .dat_we(dat_we), .dat_wdata(dat_wdata),
        .pad_in(pad_in), .rd_data(rd_data), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Independent model of the pads and readback from the requirements.
    task automatic expect_all(string req);
        logic [15:0] e_oe, e_out, e_rd;
        for (int p = 0; p < 16; p++) begin
            logic en, lvl;
            en  = port_en[p/8];
            lvl = sh[p] ^ cfg_inv[p];
            e_oe[p]  = en && !cfg_dir[p] && (!cfg_od[p] || !lvl);
            e_out[p] = en && !cfg_dir[p] && !cfg_od[p] && lvl;
            e_rd[p]  = !en ? 1'b0 : (cfg_dir[p] ? (pad_in[p] ^ cfg_inv[p]) : sh[p]);
        end
        chk(req, "pad_oe", pad_oe, e_oe);
        chk(req, "pad_out", pad_out, e_out);
        chk(req, "rd_data", rd_data, e_rd);
    endtask

    task automatic wr(int port, logic [7:0] v);
        @(negedge clk);
        dat_we = 2'b00;
        dat_we[port] = 1'b1;
        dat_wdata = v;
        @(negedge clk);
        dat_we = 2'b00;
        if (port_en[port]) sh[port*8 +: 8] = v;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        port_en = 2'b11; cfg_dir = '0; cfg_inv = '0; cfg_od = '0;
        pad_in = '0; dat_we = '0; dat_wdata = '0; sh = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset oe", pad_oe, 16'hFFFF);
        chk("R1", "reset out", pad_out, 16'h0000);
        chk("R1", "reset rd", rd_data, 16'h0000);
    endtask

    task automatic t_pushpull();
        wr(0, 8'hA5);
        wr(1, 8'h3C);
        chk("R4", "pp out", pad_out, 16'h3CA5);
        expect_all("R4");
        wr(1, 8'h01);
        wr(0, 8'h00);
        chk("R2", "pin8 only", pad_out, 16'h0100);
        chk("R11", "port0 write left port1", rd_data, 16'h0100);
    endtask

    task automatic t_invert();
        wr(0, 8'h0F);
        wr(1, 8'hF0);
        @(negedge clk);
        cfg_inv = 16'h00FF;
        @(negedge clk);
        chk("R6", "inverted drive", pad_out, 16'hF0F0);
        chk("R8", "out readback ignores inv", rd_data, 16'hF00F);
        expect_all("R6");
        cfg_inv = '0;
    endtask

    task automatic t_opendrain();
        cfg_od = 16'hFFFF;
        wr(0, 8'h5A);
        wr(1, 8'hC3);
        chk("R5", "od oe", pad_oe, ~16'hC35A);
        chk("R5", "od out", pad_out, 16'h0000);
        cfg_inv = 16'h0F00;
        @(negedge clk);
        expect_all("R5");
        cfg_od = 16'h00F0;
        @(negedge clk);
        expect_all("R5");
        cfg_od = '0; cfg_inv = '0;
    endtask

    task automatic t_input();
        cfg_dir = 16'hFFFF;
        pad_in = 16'h0000;
        settle();
        chk("R3", "inputs released", pad_oe, 16'h0000);
        chk("R3", "inputs out low", pad_out, 16'h0000);
        pad_in = 16'h5AC3;
        @(negedge clk);
        chk("R7", "one edge", rd_data, 16'h0000);
        @(negedge clk);
        chk("R7", "two edges", rd_data, 16'h5AC3);
        cfg_inv = 16'h00FF;
        @(negedge clk);
        chk("R6", "input inverted", rd_data, 16'h5A3C);
        expect_all("R6");
        cfg_inv = '0;
    endtask

    task automatic t_disable();
        cfg_dir = 16'h0000;
        wr(1, 8'h96);
        port_en = 2'b01;
        @(negedge clk);
        chk("R9", "off oe", pad_oe & 16'hFF00, 16'h0000);
        chk("R9", "off rd", rd_data & 16'hFF00, 16'h0000);
        expect_all("R9");
        wr(1, 8'hFF);
        port_en = 2'b11;
        @(negedge clk);
        chk("R10", "latch kept", rd_data & 16'hFF00, 16'h9600);
        port_en = 2'b10;
        @(negedge clk);
        chk("R9", "port0 off", pad_oe & 16'h00FF, 16'h0000);
        port_en = 2'b11;
    endtask

    task automatic t_rmw();
        logic [7:0] rb;
        cfg_dir = 16'h000F;
        wr(0, 8'hA0);
        pad_in = 16'h0005;
        settle();
        rb = rd_data[7:0];
        chk("R11", "read before rmw", {8'h0, rb}, 16'h00A5);
        wr(0, rb | 8'h40);
        chk("R11", "upper kept, bit6 set", {8'h0, rd_data[7:4], 4'h0}, 16'h00E0);
        expect_all("R11");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_pushpull();
        t_invert();
        t_opendrain();
        t_input();
        t_disable();
        t_rmw();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule